// File: doc/BRIEF.md
# Multi-drop JTAG selection controller

This block decides whether one node on a shared backplane scan bus takes part in the current scan. It carries its own 16-state TAP controller and instruction shift register. On reset it enters a waiting state with the primary data output disabled. While waiting, whatever the host shifts into the instruction register is read as an address at Update-IR. The address is matched against the node's strapped slot number, against a broadcast code, and against four multicast group codes.

A node that is addressed individually drives its test data output and answers normal instructions. A node reached by broadcast or by its multicast group follows the TAP but keeps its output disabled, so many boards can be driven at once without contention. A node whose address did not match ignores every further address until the leave-selection opcode is seen. The two-bit group register can be written only while the node is individually selected.

Top module: `jtag_drop_select`

## Requirements
- R1: After `rst_n` low, or once the TAP has spent one edge in Test-Logic-Reset, the node waits for selection with `sel_one`=0, `sel_many`=0, `sel_n`=1 and `tdo_oe`=0.
- R2: While waiting, at Update-IR the low 6 bits of the 8-bit instruction shift value are compared with `slot_addr`. A match sets `sel_one`. The top 2 bits play no part.
- R3: A node strapped to a slot of 59 or above is never individually selected. Slot 59 is the broadcast code, and 60 to 63 are reserved.
- R4: Low bits 111011 (59) set `sel_many` on every waiting node. `tdo_oe` stays 0 in later shifts.
- R5: Low bits 1111gg set `sel_many` when gg equals the group register. Otherwise the node becomes unselected.
- R6: Any other address moves the node to the unselected state. Later addresses are ignored until the leave opcode is loaded.
- R7: Loading the leave opcode C3 hex at Update-IR returns a selected, multicast or unselected node to waiting.
- R8: The group register is written at Update-DR while the instruction is 03 hex and the node is individually selected. Capture-DR loads its current value, which is shifted out LSB first.
- R9: The group register clears to 00 on `rst_n` or Test-Logic-Reset. It keeps its value across `lsp_rst_n`.
- R10: Five TCK cycles with TMS high reach Test-Logic-Reset and hence the waiting state.
- R11: A low level on `lsp_rst_n` at a rising TCK edge returns the node to waiting.
- R12: `sel_n` is low exactly while `sel_one` is high.
- R13: `tdo_oe` changes on falling TCK edges. It is high only in Shift-IR or Shift-DR of an individually selected node. Shift-IR then presents the capture pattern 01 hex, LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low test reset, sampled on rising TCK |
| lsp_rst_n | input | 1 | Active-low reset back to waiting, keeps the group register |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| slot_addr | input | ADDR_W | Strapped slot number of this node |
| tdo | output | 1 | Test data out, valid when `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for the shared TDO line |
| sel_one | output | 1 | Node is individually selected |
| sel_n | output | 1 | Active-low copy of the individual selection |
| sel_many | output | 1 | Node is selected by broadcast or multicast group |

## Verification
The bench builds the block with its default parameters: an 8-bit instruction register, a 6-bit slot address, and the leave and group opcodes C3 and 03 hex. With these values the broadcast code, the reserved slots 60 to 63 and all four group codes are real 8-bit scans. So the bench can strap slots 59 and 60 and show that the upper two instruction bits are ignored (C5 hex selects slot 5). It can also show that the same group code selects or deselects a node depending on the group register written beforehand.

// File: rtl/msel_pkg.sv
// Shared types for the multi-drop selection controller.
// Assumes the standard 16-state TAP and a 2-bit multicast group field.
package msel_pkg;

    typedef enum logic [3:0] {
        TS_TLR, TS_RTI,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_st_t;

    typedef enum logic [1:0] {
        SEL_WAIT,   // waiting for an address
        SEL_ONE,    // individually selected, TDO may drive
        SEL_MANY,   // broadcast or group selected, TDO off
        SEL_OFF     // address missed, ignoring addresses
    } sel_st_t;

    localparam int GRP_W = 2;

endpackage

// File: rtl/msel_tap.sv
// Standard 16-state TAP controller.
// Assumes rst_n is an active-low reset sampled on rising tck.
module msel_tap
    import msel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tms,
    output tap_st_t st
);

    tap_st_t nxt;

    // Next-state table of the TAP.
    always_comb begin
        unique case (st)
            TS_TLR:    nxt = tms ? TS_TLR    : TS_RTI;
            TS_RTI:    nxt = tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_IR: nxt = tms ? TS_TLR    : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            default:   nxt = tms ? TS_SEL_DR : TS_RTI;
        endcase
    end

    // State register with synchronous reset to Test-Logic-Reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TS_TLR;
        else        st <= nxt;
    end

endmodule

// File: rtl/msel_ir.sv
// Instruction shift and hold register.
// The shift stage doubles as the address carrier while the node waits.
// The hold stage resets to all ones, which decodes as bypass.
module msel_ir
    import msel_pkg::*;
#(
    parameter int             IR_W    = 8,
    parameter logic [IR_W-1:0] CAP_PAT = IR_W'(1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tap_st_t         st,
    input  logic            tdi,
    output logic [IR_W-1:0] sh,
    output logic [IR_W-1:0] instr
);

    // Capture the fixed pattern, then shift LSB first toward tdo.
    always_ff @(posedge clk) begin
        if (!rst_n)              sh <= CAP_PAT;
        else if (st == TS_CAP_IR) sh <= CAP_PAT;
        else if (st == TS_SH_IR)  sh <= {tdi, sh[IR_W-1:1]};
    end

    // Latch the shifted value as the current instruction at Update-IR.
    always_ff @(posedge clk) begin
        if (!rst_n || st == TS_TLR) instr <= '1;
        else if (st == TS_UPD_IR)   instr <= sh;
    end

endmodule

// File: rtl/msel_grp.sv
// Two-bit multicast group data register.
// Assumes wr_en is high only while the group-select instruction is
// active on an individually selected node.
module msel_grp
    import msel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tap_st_t          st,
    input  logic             tdi,
    input  logic             wr_en,
    output logic [GRP_W-1:0] grp,
    output logic             sout
);

    logic [GRP_W-1:0] sh;

    // Shift path: capture the held value, then shift LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)                       sh <= '0;
        else if (wr_en && st == TS_CAP_DR) sh <= grp;
        else if (wr_en && st == TS_SH_DR)  sh <= {tdi, sh[GRP_W-1:1]};
    end

    // Held value: cleared by test reset, written at Update-DR.
    always_ff @(posedge clk) begin
        if (!rst_n || st == TS_TLR)       grp <= '0;
        else if (wr_en && st == TS_UPD_DR) grp <= sh;
    end

    assign sout = sh[0];

    // R8: outside a write the group value does not move.
    a_r8_grp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && st == TS_UPD_DR) && st != TS_TLR) |=> $stable(grp));

endmodule

// File: rtl/msel_decide.sv
// Selection state machine. The address is taken from the instruction
// shift value at Update-IR. Codes at the top of the address range are
// the broadcast code and the four group codes.
// Assumes slot_addr is static between resets.
module msel_decide
    import msel_pkg::*;
#(
    parameter int              IR_W    = 8,
    parameter int              ADDR_W  = 6,
    parameter logic [IR_W-1:0] LEAVE_OP = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsp_rst_n,
    input  tap_st_t           st,
    input  logic [IR_W-1:0]   ir_sh,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [GRP_W-1:0]  grp,
    output sel_st_t           state
);

    localparam int                NCODE = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BCAST = ADDR_W'(NCODE - 5);
    localparam logic [ADDR_W-GRP_W-1:0] GRP_TAG = '1;

    logic [ADDR_W-1:0] addr;
    logic              hit_one, hit_all, hit_grp, is_leave;
    sel_st_t           nxt;

    // Address decode of the shifted value; upper IR bits are not used.
    always_comb begin
        addr     = ir_sh[ADDR_W-1:0];
        hit_one  = (addr == slot_addr) && (slot_addr < BCAST);
        hit_all  = (addr == BCAST);
        hit_grp  = (addr[ADDR_W-1:GRP_W] == GRP_TAG) && (addr[GRP_W-1:0] == grp);
        is_leave = (ir_sh == LEAVE_OP);
    end

    // Transition rules, evaluated once per Update-IR.
    always_comb begin
        nxt = state;
        if (st == TS_UPD_IR) begin
            unique case (state)
                SEL_WAIT: begin
                    if (hit_one)                nxt = SEL_ONE;
                    else if (hit_all || hit_grp) nxt = SEL_MANY;
                    else                        nxt = SEL_OFF;
                end
                default: if (is_leave) nxt = SEL_WAIT;
            endcase
        end
    end

    // State register; every reset path returns to waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !lsp_rst_n || st == TS_TLR) state <= SEL_WAIT;
        else                                      state <= nxt;
    end

    // R1: one edge in Test-Logic-Reset leaves the node waiting.
    a_r1_tlr_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_TLR) |=> (state == SEL_WAIT));

    // R3: a node on a non-individual slot never becomes selected alone.
    a_r3_reserved_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_UPD_IR && state == SEL_WAIT && slot_addr >= BCAST)
        |=> (state != SEL_ONE));

    // R6: an unselected node stays so until an Update-IR or a reset.
    a_r6_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEL_OFF && st != TS_UPD_IR && st != TS_TLR && lsp_rst_n)
        |=> (state == SEL_OFF));

endmodule

// File: rtl/jtag_drop_select.sv
// Multi-drop JTAG selection controller top.
// Joins the TAP, instruction register, selection machine and group
// register, and drives the primary TDO and its enable on falling tck.
// Assumes tck is the only clock and rst_n is sampled on both edges.
module jtag_drop_select
    import msel_pkg::*;
#(
    parameter int              IR_W     = 8,
    parameter int              ADDR_W   = 6,
    parameter logic [IR_W-1:0] LEAVE_OP = 8'hC3,
    parameter logic [IR_W-1:0] GRP_OP   = 8'h03
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              lsp_rst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              sel_one,
    output logic              sel_n,
    output logic              sel_many
);

    tap_st_t          tap_st;
    sel_st_t          sel_st;
    logic [IR_W-1:0]  ir_sh, instr;
    logic [GRP_W-1:0] grp;
    logic             grp_sout, grp_wr, byp, dr_out, in_shift;

    msel_tap u_tap (
        .clk   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .st    (tap_st)
    );

    msel_ir #(.IR_W(IR_W)) u_ir (
        .clk   (tck),
        .rst_n (rst_n),
        .st    (tap_st),
        .tdi   (tdi),
        .sh    (ir_sh),
        .instr (instr)
    );

    msel_decide #(.IR_W(IR_W), .ADDR_W(ADDR_W), .LEAVE_OP(LEAVE_OP)) u_dec (
        .clk       (tck),
        .rst_n     (rst_n),
        .lsp_rst_n (lsp_rst_n),
        .st        (tap_st),
        .ir_sh     (ir_sh),
        .slot_addr (slot_addr),
        .grp       (grp),
        .state     (sel_st)
    );

    assign grp_wr = (sel_st == SEL_ONE) && (instr == GRP_OP);

    msel_grp u_grp (
        .clk   (tck),
        .rst_n (rst_n),
        .st    (tap_st),
        .tdi   (tdi),
        .wr_en (grp_wr),
        .grp   (grp),
        .sout  (grp_sout)
    );

    // One-bit bypass register used by every other instruction.
    always_ff @(posedge tck) begin
        if (!rst_n || tap_st == TS_CAP_DR) byp <= 1'b0;
        else if (tap_st == TS_SH_DR)       byp <= tdi;
    end

    // Output source selection for the data path.
    always_comb begin
        dr_out   = grp_wr ? grp_sout : byp;
        in_shift = (tap_st == TS_SH_IR) || (tap_st == TS_SH_DR);
    end

    // Falling-edge output stage, enabled only for a lone selected node.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (tap_st == TS_SH_IR) ? ir_sh[0] : dr_out;
            tdo_oe <= in_shift && (sel_st == SEL_ONE);
        end
    end

    assign sel_one  = (sel_st == SEL_ONE);
    assign sel_n    = !sel_one;
    assign sel_many = (sel_st == SEL_MANY);

    // R13: the enable is only seen in a shift state.
    a_r13_oe_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (tap_st == TS_SH_IR || tap_st == TS_SH_DR));

    // R13: the enable is only seen on an individually selected node.
    a_r13_oe_needs_one: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (sel_st == SEL_ONE));

    // R4: a node selected as one of many never drives the shared line.
    a_r4_many_quiet: assert property (@(posedge tck) disable iff (!rst_n)
        sel_many |-> !tdo_oe);

endmodule

// File: tb/jtag_drop_select_test.sv
module jtag_drop_select_test;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsp_rst_n = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [5:0] slot_addr = 6'd5;
    logic       tdo, tdo_oe, sel_one, sel_n, sel_many;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    jtag_drop_select uut (
        .tck       (tck),
        .rst_n     (rst_n),
        .lsp_rst_n (lsp_rst_n),
        .tms       (tms),
        .tdi       (tdi),
        .slot_addr (slot_addr),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .sel_one   (sel_one),
        .sel_n     (sel_n),
        .sel_many  (sel_many)
    );

    always #5 tck = ~tck;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One TCK cycle: observe outputs after the falling edge, then drive.
    task automatic step(input logic m, input logic d, output logic o_tdo, output logic o_oe);
        @(negedge tck);
        #1;
        o_tdo = tdo;
        o_oe  = tdo_oe;
        tms   = m;
        tdi   = d;
        @(posedge tck);
        #1;
    endtask

    task automatic step0(input logic m);
        logic a, b;
        step(m, 1'b0, a, b);
    endtask

    // Reset, strap the slot while reset is low, end in Run-Test/Idle.
    task automatic do_reset(input logic [5:0] slot);
        @(negedge tck);
        rst_n = 1'b0;
        slot_addr = slot;
        step0(1'b1);
        step0(1'b1);
        @(negedge tck);
        rst_n = 1'b1;
        step0(1'b0);
    endtask

    // IR scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan_ir(input logic [7:0] v, output logic [7:0] got,
                           output logic oe_any, output logic oe_all);
        logic o, e;
        oe_any = 1'b0;
        oe_all = 1'b1;
        step0(1'b1);
        step0(1'b1);
        step0(1'b0);
        step0(1'b0);
        for (int i = 0; i < 8; i++) begin
            step((i == 7), v[i], o, e);
            got[i] = o;
            oe_any |= e;
            oe_all &= e;
        end
        step0(1'b1);
        step0(1'b0);
    endtask

    task automatic ir(input logic [7:0] v);
        logic [7:0] g;
        logic a, b;
        scan_ir(v, g, a, b);
    endtask

    // Two-bit DR scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan_dr2(input logic [1:0] v, output logic [1:0] got);
        logic o, e;
        step0(1'b1);
        step0(1'b0);
        step0(1'b0);
        for (int i = 0; i < 2; i++) begin
            step((i == 1), v[i], o, e);
            got[i] = o;
        end
        step0(1'b1);
        step0(1'b0);
    endtask

    task automatic t_reset_state();
        do_reset(6'd5);
        check(sel_one == 1'b0 && sel_many == 1'b0, "R1 reset selection", {sel_one, sel_many}, 0);
        check(sel_n == 1'b1, "R1 reset sel_n", sel_n, 1);
        check(tdo_oe == 1'b0, "R1 reset tdo_oe", tdo_oe, 0);
    endtask

    task automatic t_single_match();
        logic [7:0] g;
        logic any, all;
        do_reset(6'd5);
        scan_ir(8'hC5, g, any, all);
        check(any == 1'b0, "R13 no enable while waiting", any, 0);
        check(sel_one == 1'b1, "R2 address match ignoring top bits", sel_one, 1);
        check(sel_n == 1'b0, "R12 sel_n low when selected", sel_n, 0);
        scan_ir(8'hFF, g, any, all);
        check(all == 1'b1, "R13 enable through whole shift", all, 1);
        check(g == 8'h01, "R13 capture pattern", g, 8'h01);
    endtask

    task automatic t_leave();
        do_reset(6'd5);
        ir(8'h05);
        ir(8'hC3);
        check(sel_one == 1'b0 && sel_n == 1'b1, "R7 leave from selected", sel_one, 0);
        ir(8'h05);
        check(sel_one == 1'b1, "R7 waiting again after leave", sel_one, 1);
    endtask

    task automatic t_mismatch();
        do_reset(6'd5);
        ir(8'h07);
        check(sel_one == 1'b0 && sel_many == 1'b0, "R6 mismatch unselects", {sel_one, sel_many}, 0);
        ir(8'h05);
        check(sel_one == 1'b0, "R6 later address ignored", sel_one, 0);
        ir(8'hC3);
        ir(8'h05);
        check(sel_one == 1'b1, "R6 R7 leave then match", sel_one, 1);
    endtask

    task automatic t_reserved();
        do_reset(6'd60);
        ir(8'h3C);
        check(sel_one == 1'b0 && sel_n == 1'b1, "R3 slot 60 not alone", sel_one, 0);
        do_reset(6'd59);
        ir(8'h3B);
        check(sel_one == 1'b0 && sel_many == 1'b1, "R3 slot 59 only broadcast", {sel_one, sel_many}, 1);
    endtask

    task automatic t_broadcast();
        logic [7:0] g;
        logic any, all;
        do_reset(6'd5);
        ir(8'hFB);
        check(sel_many == 1'b1 && sel_one == 1'b0, "R4 broadcast selects", {sel_one, sel_many}, 1);
        check(sel_n == 1'b1, "R12 sel_n high under broadcast", sel_n, 1);
        scan_ir(8'hFF, g, any, all);
        check(any == 1'b0, "R4 no enable under broadcast", any, 0);
        ir(8'hC3);
        check(sel_many == 1'b0, "R7 leave from broadcast", sel_many, 0);
    endtask

    task automatic t_group();
        logic [1:0] g;
        do_reset(6'd5);
        ir(8'h05);
        ir(8'h03);
        scan_dr2(2'b10, g);
        check(g == 2'b00, "R8 first capture shows 00", g, 0);
        scan_dr2(2'b10, g);
        check(g == 2'b10, "R8 capture shows written group", g, 2);
        ir(8'hC3);
        ir(8'h3E);
        check(sel_many == 1'b1, "R5 own group code selects", sel_many, 1);
        ir(8'hC3);
        ir(8'h3C);
        check(sel_many == 1'b0 && sel_one == 1'b0, "R5 other group code unselects", sel_many, 0);
        ir(8'hC3);
        ir(8'h05);
        for (int i = 0; i < 5; i++) step0(1'b1);
        step0(1'b0);
        check(sel_one == 1'b0, "R10 five TMS high back to waiting", sel_one, 0);
        ir(8'h3E);
        check(sel_many == 1'b0, "R9 group cleared by test reset", sel_many, 0);
    endtask

    task automatic t_lsp_reset();
        logic [1:0] g;
        do_reset(6'd5);
        ir(8'h05);
        ir(8'h03);
        scan_dr2(2'b01, g);
        @(negedge tck);
        lsp_rst_n = 1'b0;
        tms = 1'b0;
        @(posedge tck);
        #1;
        @(negedge tck);
        lsp_rst_n = 1'b1;
        @(posedge tck);
        #1;
        check(sel_one == 1'b0, "R11 lsp reset to waiting", sel_one, 0);
        ir(8'h3D);
        check(sel_many == 1'b1, "R9 group kept over lsp reset", sel_many, 1);
    endtask

    task automatic t_rst_from_off();
        do_reset(6'd5);
        ir(8'h09);
        do_reset(6'd5);
        ir(8'h05);
        check(sel_one == 1'b1, "R1 reset leaves unselected", sel_one, 1);
    endtask

    initial begin
        t_reset_state();
        t_single_match();
        t_leave();
        t_mismatch();
        t_reserved();
        t_broadcast();
        t_group();
        t_lsp_reset();
        t_rst_from_off();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge tck);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule